// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal single-word request bus and an external asynchronous static RAM of 256K words by 16 bits. Each accepted request becomes one complete memory cycle. The controller drives the 18-bit address, an active-low and an active-high chip select, an output enable, a write enable and one strobe per byte lane. The bidirectional data pins are handled through three signals: a data-out bus, a data-in bus and a drive enable.

All wait counts are derived at elaboration from the clock period and the speed grade (55, 70 or 100 ns). Each count is a nanosecond figure divided by the clock period, rounded up, with a floor of one cycle. An access runs through four phases: idle, setup, access wait, and recovery.

- A write lowers write enable for the write-pulse count and never enables the memory outputs.
- A read holds output enable low for the address-access count. The data is registered at the end of that window, with unselected lanes forced to zero.
- After any read, a write is held back until a turnaround gap has expired, so the controller never drives the pins while the memory may still be driving them.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and afterwards until a request is accepted, the memory pins are in the deselected state. That means active-low select high, active-high select low, output enable high, write enable high, both byte strobes high and the data drive enable low. Acknowledge and read-valid are low.
- R2: A read lowers output enable for ceil(grade/clock) cycles, which is 14 at the defaults. Its acknowledge is sampled high 17 rising edges after request assertion, counting the accepting edge as the first. Read-valid is high exactly in the acknowledge cycle of a read, and only then.
- R3: A request is accepted only when the controller is idle and acknowledge is low. Acknowledge is high for exactly one cycle. Request fields changed while an access is in progress have no effect on that access.
- R4: In a write, request byte-enable bit 0 lowers the lower strobe and selects data bits 7:0, and bit 1 lowers the upper strobe and selects bits 15:8. Lanes whose enable is 0 keep their old contents, so a write with enable 0 changes nothing.
- R5: Returned read data carries the memory contents on the lanes whose enable bit is 1 and zero on the others. With enable 0 the returned word is 0.
- R6: A write keeps output enable high throughout. It lowers write enable for exactly ceil(tWP/clock) cycles, which is 12 cycles (48 ns) at the defaults. Write data is driven while write enable rises. The acknowledge follows 15 edges after request assertion when no turnaround is pending.
- R7: After output enable rises at the end of a read, the data drive enable stays low for at least TURN_CYC cycles. A write requested right after a read acknowledge starts driving exactly TURN_CYC+1 cycles after output enable rose, and its acknowledge arrives 19 edges after request assertion at the defaults.
- R8: The address, chip selects and byte strobes stay constant while the memory is selected. The chip is deselected in the acknowledge cycle, so the address only changes while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte enables (bit 0 low lane, bit 1 high lane) |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_valid | output | 1 | Read data valid (with acknowledge of a read) |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The two functions that can coincide are the completion of a read and a write request waiting behind it. In one cycle, the read's acknowledge, the turnaround countdown and the pending write's acceptance test all meet.

The bench provokes this on every write that follows a read in its address and byte-enable sweep, by raising the write request on the first cycle after the read acknowledge. It judges the outcome by the exact acknowledge latency and by the measured gap between output enable rising and the drive enable rising. A memory model also flags any cycle in which both sides would drive the pins.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW       = 18,
  parameter int CLK_NS   = 4,
  parameter int GRADE_NS = 55,
  parameter int TURN_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [15:0]   req_wdata,
  output logic          req_ack,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [15:0]   mem_dq_out,
  input  logic [15:0]   mem_dq_in,
  output logic          mem_dq_oe
);
  function automatic int ceil_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int T_WP    = (GRADE_NS == 55) ? 45 : (GRADE_NS == 70) ? 55 : 70;
  localparam int T_OHZ   = (GRADE_NS == 55) ? 20 : (GRADE_NS == 70) ? 25 : 30;
  localparam int CYC_TOT = ceil_cyc(GRADE_NS);
  localparam int RD_CYC  = ceil_cyc(GRADE_NS);
  localparam int WP_CYC  = ceil_cyc(T_WP);
  localparam int RD_LEFT = CYC_TOT - 1 - RD_CYC;
  localparam int WR_LEFT = CYC_TOT - 1 - WP_CYC;
  localparam int RD_REC  = (RD_LEFT < 1) ? 1 : RD_LEFT;
  localparam int WR_REC  = (WR_LEFT < 1) ? 1 : WR_LEFT;
  localparam int MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_R   = (RD_REC > WR_REC) ? RD_REC : WR_REC;
  localparam int MAXC    = (MAX_A > MAX_R) ? MAX_A : MAX_R;
  localparam int CW      = $clog2(MAXC + 1);
  localparam int TW      = $clog2(TURN_CYC + 1) + 1;

  if (GRADE_NS != 55 && GRADE_NS != 70 && GRADE_NS != 100) begin : g_bad_grade
    $error("speed grade must be 55, 70 or 100 ns");
  end
  if (CLK_NS > T_WP) begin : g_slow_clk
    $error("clock period exceeds the minimum write pulse");
  end
  if (TURN_CYC < 1 || TURN_CYC * CLK_NS < T_OHZ) begin : g_short_turn
    $error("turnaround gap shorter than output release time");
  end

  typedef enum logic [1:0] {IDLE, SETUP, ACCESS, HOLD} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  turn;
  logic           is_wr, ack_r, rv_r;
  logic [1:0]     be_r;
  logic [AW-1:0]  addr_r;
  logic [15:0]    wdata_r, rdata_r;

  wire sel       = (st != IDLE);
  wire accept    = (st == IDLE) && req_valid && !ack_r && (!req_write || turn == '0);
  wire [15:0] lane_mask = {{8{be_r[1]}}, {8{be_r[0]}}};

  assign mem_addr   = addr_r;
  assign mem_ce_n   = !sel;
  assign mem_ce2    = sel;
  assign mem_lb_n   = !(sel && be_r[0]);
  assign mem_ub_n   = !(sel && be_r[1]);
  assign mem_oe_n   = !(st == ACCESS && !is_wr);
  assign mem_we_n   = !(st == ACCESS && is_wr);
  assign mem_dq_oe  = sel && is_wr;
  assign mem_dq_out = wdata_r;
  assign req_ack    = ack_r;
  assign rsp_valid  = rv_r;
  assign rsp_rdata  = rdata_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      turn    <= '0;
      is_wr   <= 1'b0;
      be_r    <= '0;
      addr_r  <= '0;
      wdata_r <= '0;
      rdata_r <= '0;
      ack_r   <= 1'b0;
      rv_r    <= 1'b0;
    end else begin
      ack_r <= 1'b0;
      rv_r  <= 1'b0;
      if (turn != '0) turn <= turn - 1'b1;
      case (st)
        IDLE: if (accept) begin
          st      <= SETUP;
          is_wr   <= req_write;
          be_r    <= req_be;
          addr_r  <= req_addr;
          wdata_r <= req_wdata;
        end
        SETUP: begin
          st  <= ACCESS;
          cnt <= is_wr ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
        end
        ACCESS: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          st  <= HOLD;
          cnt <= is_wr ? CW'(WR_REC - 1) : CW'(RD_REC - 1);
          if (!is_wr) begin
            rdata_r <= mem_dq_in & lane_mask;
            turn    <= TW'(TURN_CYC);
          end
        end
        HOLD: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          st    <= IDLE;
          ack_r <= 1'b1;
          rv_r  <= !is_wr;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module sram_ctl_chk #(
  parameter int AW       = 18,
  parameter int TURN_CYC = 6,
  parameter int WP_CYC   = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_ce2,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic          mem_dq_oe,
  input logic          req_ack,
  input logic          rsp_valid
);
  logic [7:0] wlen, gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlen <= '0;
      gap  <= 8'hFF;
    end else begin
      wlen <= mem_we_n ? 8'd0 : wlen + 8'd1;
      if (!mem_oe_n) gap <= '0;
      else if (gap != 8'hFF) gap <= gap + 8'd1;
    end
  end

  assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> wlen == 8'(WP_CYC));
  assert_pins_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
  assert_strobe_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && mem_ce2));
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> gap >= 8'(TURN_CYC));
  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  assert_rsp_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ack);
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .TURN_CYC(TURN_CYC), .WP_CYC(WP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
  .mem_dq_oe(mem_dq_oe), .req_ack(req_ack), .rsp_valid(rsp_valid));

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
  localparam int RD_N   = (55 + 3) / 4;
  localparam int WP_N   = (45 + 3) / 4;
  localparam int REC    = 1;
  localparam int TURN   = 6;
  localparam int LAT_RD = 2 + RD_N + REC;
  localparam int LAT_WR = 2 + WP_N + REC;
  localparam int LAT_WAR = (TURN - REC - 1) + LAT_WR;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = 0;
  logic [1:0]  req_be = 0;
  logic [15:0] req_wdata = 0;
  logic req_ack, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'h0000;

  always #2 clk = ~clk;

  sram_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int a);
    return 16'((a * 40503) ^ 16'h5A17);
  endfunction

  logic [15:0] mdl [int];
  logic [15:0] sb  [int];

  function automatic logic [15:0] mdl_rd(input int a);
    return mdl.exists(a) ? mdl[a] : init_word(a);
  endfunction
  function automatic logic [15:0] sb_rd(input int a);
    return sb.exists(a) ? sb[a] : init_word(a);
  endfunction

  int  wlen = 0, gap = 1000, last_gap = 0;
  bit  oe_prev = 0, sel_prev = 0;
  logic [17:0] addr_prev = 0;
  logic [1:0]  strb_prev = 0;

  always @(negedge clk) begin
    logic sel, dlo, dhi;
    logic [15:0] w;
    sel = !mem_ce_n && mem_ce2;
    dlo = sel && mem_we_n && !mem_oe_n && !mem_lb_n;
    dhi = sel && mem_we_n && !mem_oe_n && !mem_ub_n;
    w = mdl_rd(int'(mem_addr));
    mem_dq_in <= {dhi ? w[15:8] : 8'hC3, dlo ? w[7:0] : 8'h3C};
    if (rst_n) begin
      if (!mem_we_n) wlen++;
      if (!mem_we_n && !mem_oe_n) check(0, "R6 oe low during write", 0, 1);
      if (mem_dq_oe && (dlo || dhi)) check(0, "R7 bus contention", 1, 0);
      if (sel && sel_prev && (mem_addr != addr_prev || {mem_ub_n, mem_lb_n} != strb_prev))
        check(0, "R8 pins moved while selected", 32'(mem_addr), 32'(addr_prev));
      if (!mem_oe_n) gap = 0;
      else if (!mem_dq_oe && gap < 1000) gap++;
      if (mem_dq_oe && !oe_prev) last_gap = gap;
    end
    oe_prev   = mem_dq_oe;
    sel_prev  = sel;
    addr_prev = mem_addr;
    strb_prev = {mem_ub_n, mem_lb_n};
  end

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n && mem_ce2) begin
      logic [15:0] w;
      check(mem_dq_oe, "R6 data not driven at write end", 32'(mem_dq_oe), 1);
      check(wlen == WP_N, "R6 write pulse cycles", 32'(wlen), 32'(WP_N));
      w = mdl_rd(int'(mem_addr));
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      mdl[int'(mem_addr)] = w;
    end
    wlen = 0;
  end

  bit prev_rd = 0;

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd, output bit rv, output int n);
    bit scr;
    @(negedge clk);
    check(!req_ack, "R3 ack longer than one cycle", 32'(req_ack), 0);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    n = 0; scr = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!mem_ce_n && !scr) begin
        scr = 1;
        req_addr = ~a; req_be = ~be; req_wdata = ~wd; req_write = !wr;
      end
    end while (!req_ack && n < 300);
    rd = rsp_rdata; rv = rsp_valid;
    check(mem_ce_n && !mem_ce2, "R8 selected in ack cycle", 32'(mem_ce_n), 1);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] be, input logic [15:0] wd);
    logic [15:0] rd, w;
    bit rv, after_rd;
    int n;
    after_rd = prev_rd;
    w = sb_rd(int'(a));
    if (be[0]) w[7:0]  = wd[7:0];
    if (be[1]) w[15:8] = wd[15:8];
    sb[int'(a)] = w;
    do_req(1, a, be, wd, rd, rv, n);
    if (after_rd) begin
      check(n == LAT_WAR, "R7 write-after-read latency", 32'(n), 32'(LAT_WAR));
      check(last_gap == TURN + 1, "R7 turnaround gap", 32'(last_gap), 32'(TURN + 1));
    end else
      check(n == LAT_WR, "R6 write latency", 32'(n), 32'(LAT_WR));
    check(!rv, "R2 read-valid on write", 32'(rv), 0);
    prev_rd = 0;
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be, input string tag);
    logic [15:0] rd, exp;
    bit rv;
    int n;
    exp = sb_rd(int'(a)) & {{8{be[1]}}, {8{be[0]}}};
    do_req(0, a, be, 16'h0, rd, rv, n);
    check(n == LAT_RD, "R2 read latency", 32'(n), 32'(LAT_RD));
    check(rv, "R2 read-valid missing", 32'(rv), 1);
    check(rd == exp, tag, 32'(rd), 32'(exp));
    prev_rd = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
          "R1 pins in reset", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 7'b1011110);
    check(!req_ack && !rsp_valid, "R1 handshake in reset", {req_ack, rsp_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle after reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    for (int i = 0; i < 8; i++) begin
      logic [17:0] a;
      a = (i == 0) ? 18'h0 : (i == 7) ? 18'h3FFFF : 18'((i * 18'h09A5B + 5));
      for (int be = 0; be < 4; be++) begin
        do_write(a, 2'(be), 16'((i * 16'h3B1 + be * 16'h1111) ^ 16'hA0C5));
        do_read(a, 2'b11, "R4 byte-masked write result");
      end
      for (int be = 0; be < 3; be++)
        do_read(a, 2'(be), "R5 lane masking on read");
    end
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule